// File: doc/BRIEF.md
# Systolic Array Power-Enable Sequencer

This block drives the power-domain enables of a weight-stationary systolic array. When a weight tile is loaded, it inspects the weights, marks every row and every column whose weights are all zero as gated, and keeps those flags until the next tile. A compute-start launches an enable token at the top-left processing element. The token moves one diagonal per cycle, following the skewed activation wavefront, so each element is powered a fixed number of cycles before its first activation reaches it. No element needs its own idle detector.

Each array row has a small occupancy-tracked input queue. Activations are pushed into it before or during a pass. Row `r` starts issuing `WAKE` cycles after the token enters that row, one activation per cycle. After every queue has drained, the block waits `IDLE` cycles and then sends a second, clearing token along the same diagonal path, which turns the enables off behind the last activation. The datapath and the physical power switches sit outside this block: an enable here is a flag only. `WAKE` must be at least 1 and `IDLE` at least 1.

Top module: `sa_pgate_ctrl`

## Requirements
- R1: On a cycle with `w_load` high, `row_on[r]` is updated to 1 exactly when some weight in row r is nonzero, and `col_on[c]` to 1 exactly when some weight in column c is nonzero. Weight (r,c) occupies `w_tile[(r*COLS+c)*WBITS +: WBITS]`. The new flags are visible from the following cycle.
- R2: Let E0 be the rising edge that accepts a start, which happens when `start` and `ready` are high and `w_load` is low. From edge E0+r+c onward, `pe_on[r*COLS+c]` is 1 if and only if `row_on[r]` and `col_on[c]` are both 1, and it stays 1 until it is cleared by R5.
- R3: Row r issues its first queued activation at edge E0+r+WAKE and then one more at each edge while its queue is non-empty. An activation issued at edge t is reported on `pe_act[r*COLS+c]` after edge t+c. It is reported only where both `row_on[r]` and `col_on[c]` are set.
- R4: A PE never reports an activation in `pe_act` unless its `pe_on` has been high for at least WAKE cycles.
- R5: Let Ed be the first edge at which every row has started issuing (cnt at least ROWS+WAKE-2 in the cycle before) and every queue is empty. PE(r,c) drops `pe_on` at edge Ed+IDLE+r+c.
- R6: `ready` is high only when no pass is running, clearing or being flushed. It returns high at edge Ed+IDLE+ROWS+COLS-1. It is also low for the cycle that follows a weight load.
- R7: A `start` that arrives while `ready` is low has no effect on any output.
- R8: Each row queue holds up to QDEPTH entries. `q_full[r]` is high while it holds QDEPTH entries, and a push into a full queue is dropped.
- R9: A weight load clears all enable tokens and all in-flight activations in the same edge, and it aborts any running pass. Entries that are still queued are kept for the next pass.
- R10: After reset, `ready` is 1 and `row_on`, `col_on`, `pe_on`, `pe_act` and `q_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_load | input | 1 | Load strobe for the weight tile |
| w_tile | input | ROWS*COLS*WBITS | Weight tile, row-major |
| start | input | 1 | Compute-start strobe |
| in_push | input | ROWS | Per-row activation push into the row queue |
| ready | output | 1 | Block is idle and will accept a start |
| q_full | output | ROWS | Row queue full (backpressure) |
| row_on | output | ROWS | Row holds at least one nonzero weight |
| col_on | output | COLS | Column holds at least one nonzero weight |
| pe_on | output | ROWS*COLS | Per-PE power enable, index r*COLS+c |
| pe_act | output | ROWS*COLS | Activation present at a powered PE |

## Verification
The bench builds a 4x4 array with 4-bit weights, WAKE=2, IDLE=3 and three-entry queues. At that size all 256 row/column zero patterns can be swept for the detection flags. The enable, activation and ready timelines of whole passes are predicted cycle by cycle from closed-form edge arithmetic. The passes use mixed queue fills, overfilled queues, all-zero tiles, ignored starts, a start during the flush cycle, and a load that aborts a pass with entries still queued.

// File: rtl/sa_pgate_ctrl.sv
module sa_pgate_ctrl #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int WBITS  = 8,
  parameter int WAKE   = 2,
  parameter int IDLE   = 3,
  parameter int QDEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        w_load,
  input  logic [ROWS*COLS*WBITS-1:0]  w_tile,
  input  logic                        start,
  input  logic [ROWS-1:0]             in_push,
  output logic                        ready,
  output logic [ROWS-1:0]             q_full,
  output logic [ROWS-1:0]             row_on,
  output logic [COLS-1:0]             col_on,
  output logic [ROWS*COLS-1:0]        pe_on,
  output logic [ROWS*COLS-1:0]        pe_act
);
  localparam int NPE  = ROWS * COLS;
  localparam int LAST = NPE - 1;
  localparam int QW   = $clog2(QDEPTH + 1);
  localparam int CW   = $clog2(ROWS + COLS + WAKE + IDLE + QDEPTH + 4) + 1;
  localparam int AW   = $clog2(WAKE + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_OFF, ST_FLUSH} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [NPE-1:0]   tok, ctok, pipe, nz;
  logic [ROWS-1:0]  row_nz, pop, qbusy;
  logic [COLS-1:0]  col_nz;
  logic             accept, drained, inj_off, wrap;

  assign ready   = (st == ST_IDLE);
  assign accept  = start && ready && !w_load;
  assign wrap    = (st == ST_OFF) && ctok[LAST];
  assign inj_off = (st == ST_OFF) && (cnt == CW'(IDLE - 1));
  assign drained = (st == ST_RUN) && (int'(cnt) >= ROWS + WAKE - 2) && (qbusy == '0);

  always_comb begin
    row_nz = '0;
    col_nz = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        row_nz[r] = row_nz[r] | nz[r*COLS+c];
        col_nz[c] = col_nz[c] | nz[r*COLS+c];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_on <= '0;
      col_on <= '0;
    end else if (w_load) begin
      row_on <= row_nz;
      col_on <= col_nz;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (w_load) begin
      st  <= ST_FLUSH;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (start) begin st <= ST_RUN; cnt <= '0; end
        ST_RUN:   if (drained) begin st <= ST_OFF; cnt <= '0; end
                  else if (cnt != '1) cnt <= cnt + 1'b1;
        ST_OFF:   begin
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    if (ctok[LAST]) st <= ST_IDLE;
                  end
        default:  st <= ST_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [QW-1:0] q_q;
    logic          open_r, push_ok;
    assign open_r   = (st == ST_RUN) && (int'(cnt) >= r + WAKE - 1);
    assign pop[r]   = open_r && (q_q != '0) && !w_load;
    assign push_ok  = in_push[r] && (q_q != QW'(QDEPTH));
    assign q_full[r] = (q_q == QW'(QDEPTH));
    assign qbusy[r] = (q_q != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) q_q <= '0;
      else q_q <= q_q + QW'(push_ok) - QW'(pop[r]);
    end

    assert_qbound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_q <= QW'(QDEPTH));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_pr
    for (genvar c = 0; c < COLS; c++) begin : g_pc
      localparam int K = r*COLS + c;
      logic t_q, c_q, p_q, up_t, up_c, lf_t, lf_c, seed_t, seed_c, feed;
      logic [AW-1:0] age;

      assign nz[K] = |w_tile[K*WBITS +: WBITS];

      if (r > 0) begin : g_up
        assign up_t = tok[K-COLS];
        assign up_c = ctok[K-COLS];
      end else begin : g_noup
        assign up_t = 1'b0;
        assign up_c = 1'b0;
      end

      if (c > 0) begin : g_lf
        assign lf_t = tok[K-1];
        assign lf_c = ctok[K-1];
        assign feed = pipe[K-1];
      end else begin : g_nolf
        assign lf_t = 1'b0;
        assign lf_c = 1'b0;
        assign feed = pop[r];
      end

      if (K == 0) begin : g_seed
        assign seed_t = accept;
        assign seed_c = inj_off;
      end else begin : g_noseed
        assign seed_t = 1'b0;
        assign seed_c = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (!rst_n || w_load || wrap) begin
          t_q <= 1'b0;
          c_q <= 1'b0;
        end else begin
          t_q <= t_q | seed_t | up_t | lf_t;
          c_q <= c_q | seed_c | up_c | lf_c;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n || w_load) p_q <= 1'b0;
        else p_q <= feed;
      end

      assign tok[K]    = t_q;
      assign ctok[K]   = c_q;
      assign pipe[K]   = p_q;
      assign pe_on[K]  = t_q & ~c_q & row_on[r] & col_on[c];
      assign pe_act[K] = p_q & row_on[r] & col_on[c];

      always_ff @(posedge clk) begin
        if (!rst_n || !pe_on[K]) age <= '0;
        else if (age != AW'(WAKE)) age <= age + 1'b1;
      end

      assert_wake_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pe_act[K] |-> (age >= AW'(WAKE)));
    end
  end

  assert_load_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |=> (pe_on == '0 && pe_act == '0 && !ready));

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pe_on == '0 && pe_act == '0));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready && !w_load) |=> (!ready && pe_on[0] == (row_on[0] && col_on[0])));

endmodule

// File: tb/sa_pgate_ctrl_bench.sv
`timescale 1ns/1ps
module sa_pgate_ctrl_bench;
  localparam int R = 4, C = 4, WB = 4, WK = 2, ID = 3, QD = 3;

  logic clk = 1'b0, rst_n = 1'b0, w_load = 1'b0, start = 1'b0;
  logic [R*C*WB-1:0] w_tile = '0;
  logic [R-1:0] in_push = '0;
  logic ready;
  logic [R-1:0] q_full, row_on;
  logic [C-1:0] col_on;
  logic [R*C-1:0] pe_on, pe_act;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  sa_pgate_ctrl #(.ROWS(R), .COLS(C), .WBITS(WB), .WAKE(WK), .IDLE(ID), .QDEPTH(QD)) u_sa_pgate_ctrl (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_tile(w_tile), .start(start),
    .in_push(in_push), .ready(ready), .q_full(q_full), .row_on(row_on),
    .col_on(col_on), .pe_on(pe_on), .pe_act(pe_act));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_tile(input logic [R-1:0] rm, input logic [C-1:0] cm);
    for (int i = 0; i < R; i++)
      for (int j = 0; j < C; j++)
        w_tile[(i*C+j)*WB +: WB] = (rm[i] && cm[j]) ? WB'((i*C+j) % 15 + 1) : '0;
  endtask

  task automatic load(input logic [R-1:0] rm, input logic [C-1:0] cm);
    set_tile(rm, cm);
    w_load = 1'b1;
    @(negedge clk);
    w_load = 1'b0;
    chk("R1 row_on", 64'(row_on), 64'((|cm) ? rm : '0));
    chk("R1 col_on", 64'(col_on), 64'((|rm) ? cm : '0));
    @(negedge clk);
  endtask

  task automatic run_pass(input logic [R-1:0] rm, input logic [C-1:0] cm,
                          input logic [4*R-1:0] pushv, input logic [4*R-1:0] prev,
                          input int pulse_at);
    int n [R];
    int ed, tend, mx;
    int oage [R*C];
    logic [R*C-1:0] eon, eact;
    logic [R-1:0] efull;
    load(rm, cm);
    chk("R6 ready after flush", 64'(ready), 64'd1);
    mx = 0;
    for (int i = 0; i < R; i++) begin
      n[i] = int'(prev[4*i +: 4]) + int'(pushv[4*i +: 4]);
      if (n[i] > QD) n[i] = QD;
      if (int'(pushv[4*i +: 4]) > mx) mx = int'(pushv[4*i +: 4]);
    end
    for (int p = 0; p < mx; p++) begin
      for (int i = 0; i < R; i++) in_push[i] = (p < int'(pushv[4*i +: 4]));
      @(negedge clk);
    end
    in_push = '0;
    for (int i = 0; i < R; i++) efull[i] = (n[i] == QD);
    chk("R8 q_full after pushes", 64'(q_full), 64'(efull));
    ed = R + WK - 1;
    for (int i = 0; i < R; i++)
      if (n[i] > 0 && i + WK + n[i] > ed) ed = i + WK + n[i];
    tend = ed + ID + R + C - 1;
    for (int q = 0; q < R*C; q++) oage[q] = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= tend + 1; k++) begin
      for (int i = 0; i < R; i++)
        for (int j = 0; j < C; j++) begin
          eon[i*C+j]  = rm[i] && cm[j] && (k >= i + j) && (k < ed + ID + i + j);
          eact[i*C+j] = rm[i] && cm[j] && (k - j - i - WK >= 0) && (k - j - i - WK < n[i]);
        end
      chk((k > pulse_at && pulse_at >= 0) ? "R2 R5 R7 pe_on" : "R2 R5 pe_on", 64'(pe_on), 64'(eon));
      chk("R3 pe_act", 64'(pe_act), 64'(eact));
      chk("R6 ready", 64'(ready), 64'(k >= tend));
      begin
        int bad = 0;
        for (int q = 0; q < R*C; q++) begin
          if (pe_act[q] && oage[q] < WK) bad++;
          oage[q] = pe_on[q] ? oage[q] + 1 : 0;
        end
        chk("R4 enable lead before data", 64'(bad), 64'd0);
      end
      start = (k == pulse_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready", 64'(ready), 64'd1);
    chk("R10 row_on", 64'(row_on), 64'd0);
    chk("R10 col_on", 64'(col_on), 64'd0);
    chk("R10 pe_on", 64'(pe_on), 64'd0);
    chk("R10 pe_act", 64'(pe_act), 64'd0);
    chk("R10 q_full", 64'(q_full), 64'd0);

    for (int rm = 0; rm < 16; rm++)
      for (int cm = 0; cm < 16; cm++)
        load(4'(rm), 4'(cm));

    run_pass(4'hF, 4'hF, {4'd0, 4'd3, 4'd2, 4'd1}, '0, -1);
    run_pass(4'b1011, 4'b0110, {4'd1, 4'd4, 4'd3, 4'd5}, '0, 3);
    run_pass(4'b0001, 4'b1000, {4'd1, 4'd0, 4'd0, 4'd2}, '0, 10);
    run_pass(4'hF, 4'hF, '0, '0, 1);
    run_pass(4'h0, 4'h0, {4'd2, 4'd2, 4'd2, 4'd2}, '0, -1);

    set_tile(4'hF, 4'hF);
    w_load = 1'b1;
    @(negedge clk);
    w_load = 1'b0;
    start = 1'b1;
    chk("R6 ready low in flush cycle", 64'(ready), 64'd0);
    @(negedge clk);
    start = 1'b0;
    chk("R7 start in flush ignored ready", 64'(ready), 64'd1);
    chk("R7 start in flush ignored pe_on", 64'(pe_on), 64'd0);
    @(negedge clk);
    chk("R7 still idle pe_on", 64'(pe_on), 64'd0);

    in_push = 4'b0001;
    @(negedge clk);
    @(negedge clk);
    in_push = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 abort pass token at origin", 64'(pe_on), 64'h0001);
    @(negedge clk);
    set_tile(4'hF, 4'hF);
    w_load = 1'b1;
    @(negedge clk);
    w_load = 1'b0;
    chk("R9 flush pe_on", 64'(pe_on), 64'd0);
    chk("R9 flush pe_act", 64'(pe_act), 64'd0);
    chk("R9 flush ready", 64'(ready), 64'd0);
    @(negedge clk);
    chk("R9 ready after flush", 64'(ready), 64'd1);
    run_pass(4'hF, 4'hF, '0, {4'd0, 4'd0, 4'd0, 4'd2}, -1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule